// File: doc/BRIEF.md
# Byte Mask/Extract/Insert Unit

A combinational 64-bit datapath that rearranges and clears bytes inside a word. Software uses it to build unaligned loads and stores out of aligned quadword accesses. A 7-bit function code selects the operation. The unit covers three whole-word shifts and several byte-field operations. The field operations are clear (mask), extract and insert, each with a low and a high form, on fields of 1, 2, 4 or 8 bytes. Two more operations clear whole bytes under an 8-bit lane mask.

Operand A is the data. Operand B gives the shift amount, the byte offset or the lane mask, depending on the operation. The high forms of the field operations produce the part of a field that spills past the top of the 64-bit word. They treat a byte offset of zero as a special case. A function code that is not in the table gives a zero result and raises the illegal-function flag.

Top module: `byte_manip_unit`

## Requirements
- R1: Codes 0x39, 0x34 and 0x3c shift A left logically, right logically and right arithmetically. The shift amount is B[5:0], and B[63:6] has no effect.
- R2: Every field operation takes its byte offset `o` from B[2:0] and shifts by 8*o bits. B[63:3] has no effect on these operations. The field width in bytes is set by bits [6:4] of the code: 0→1, 1→2, 2→4, 3→8, 5→2, 6→4, 7→8.
- R3: Clear-low (0x02, 0x12, 0x22, 0x32) returns A with byte j zeroed for o ≤ j < o+width, for j in 0..7.
- R4: Clear-high (0x52, 0x62, 0x72) returns A unchanged when o = 0. Otherwise it returns A with byte j zeroed for j < o+width−8.
- R5: Extract-low (0x06, 0x16, 0x26, 0x36) returns A shifted right by 8*o bits, truncated to the field width.
- R6: Extract-high (0x5a, 0x6a, 0x7a) returns A shifted left by (64−8*o) mod 64 bits, truncated to the field width.
- R7: Insert-low (0x0b, 0x1b, 0x2b, 0x3b) truncates A to the field width, then shifts it left by 8*o bits.
- R8: Insert-high (0x57, 0x67, 0x77) returns zero when o = 0. Otherwise it returns the truncated field shifted right by 64−8*o bits.
- R9: Code 0x30 zeroes byte i of A wherever B[i] = 1. Code 0x31 zeroes byte i wherever B[i] = 0. B[63:8] has no effect on either.
- R10: Any other code gives a zero result with the illegal flag at 1. Every code listed in R1 to R9 gives the illegal flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Data operand |
| b_i | input | 64 | Shift amount, byte offset or lane mask |
| fn_i | input | 7 | Function code |
| res_o | output | 64 | Result |
| bad_fn_o | output | 1 | Illegal-function flag |

## Verification
The unit has no registers, so every result and the illegal flag are due in the same cycle as the operands and code that produce them. The bench changes inputs on the falling clock edge and samples 1 ns later, when the logic has settled and well before the next rising edge. The sweeps cover every field code at all eight offsets, every shift amount, all 256 lane masks and all 128 function codes. Each sweep keeps garbage in the upper bits of B, which exercises the "no effect" parts of R1, R2 and R9.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int WORD_W  = 64;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int OFS_W   = $clog2(LANES);
    localparam int SHAMT_W = $clog2(WORD_W);
    localparam int FUNC_W  = 7;

    typedef enum logic [FUNC_W-1:0] {
        F_SHL    = 7'h39, F_SHR    = 7'h34, F_SAR    = 7'h3c,
        F_CLRL_B = 7'h02, F_CLRL_W = 7'h12, F_CLRL_L = 7'h22, F_CLRL_Q = 7'h32,
        F_CLRH_W = 7'h52, F_CLRH_L = 7'h62, F_CLRH_Q = 7'h72,
        F_GETL_B = 7'h06, F_GETL_W = 7'h16, F_GETL_L = 7'h26, F_GETL_Q = 7'h36,
        F_GETH_W = 7'h5a, F_GETH_L = 7'h6a, F_GETH_Q = 7'h7a,
        F_PUTL_B = 7'h0b, F_PUTL_W = 7'h1b, F_PUTL_L = 7'h2b, F_PUTL_Q = 7'h3b,
        F_PUTH_W = 7'h57, F_PUTH_L = 7'h67, F_PUTH_Q = 7'h77,
        F_ZAP    = 7'h30, F_KEEP   = 7'h31
    } func_e;

    typedef enum logic [2:0] {K_NONE, K_SHIFT, K_CLR, K_GET, K_PUT, K_ZAP} kind_e;
    typedef enum logic [1:0] {W8, W16, W32, W64} fwid_e;
    typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} shdir_e;

    typedef struct packed {
        kind_e  kind;
        logic   hi;
        logic   inv;
        fwid_e  wid;
        shdir_e dir;
        logic   bad;
    } dec_t;

    // All-ones field of 8, 16, 32 or 64 bits, right aligned
    function automatic logic [WORD_W-1:0] field_ones(input fwid_e w);
        logic [WORD_W:0] t;
        t = ((WORD_W+1)'(1) << (LANE_W << w)) - (WORD_W+1)'(1);
        return t[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
    import bmx_pkg::*;
(
    input  logic [FUNC_W-1:0] fn_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = '{kind: K_NONE, hi: 1'b0, inv: 1'b0, wid: W8, dir: SH_LL, bad: 1'b0};
        case (fn_i)
            F_SHL:    begin dec_o.kind = K_SHIFT; dec_o.dir = SH_LL; end
            F_SHR:    begin dec_o.kind = K_SHIFT; dec_o.dir = SH_RL; end
            F_SAR:    begin dec_o.kind = K_SHIFT; dec_o.dir = SH_RA; end
            F_CLRL_B: begin dec_o.kind = K_CLR; dec_o.wid = W8;  end
            F_CLRL_W: begin dec_o.kind = K_CLR; dec_o.wid = W16; end
            F_CLRL_L: begin dec_o.kind = K_CLR; dec_o.wid = W32; end
            F_CLRL_Q: begin dec_o.kind = K_CLR; dec_o.wid = W64; end
            F_CLRH_W: begin dec_o.kind = K_CLR; dec_o.wid = W16; dec_o.hi = 1'b1; end
            F_CLRH_L: begin dec_o.kind = K_CLR; dec_o.wid = W32; dec_o.hi = 1'b1; end
            F_CLRH_Q: begin dec_o.kind = K_CLR; dec_o.wid = W64; dec_o.hi = 1'b1; end
            F_GETL_B: begin dec_o.kind = K_GET; dec_o.wid = W8;  end
            F_GETL_W: begin dec_o.kind = K_GET; dec_o.wid = W16; end
            F_GETL_L: begin dec_o.kind = K_GET; dec_o.wid = W32; end
            F_GETL_Q: begin dec_o.kind = K_GET; dec_o.wid = W64; end
            F_GETH_W: begin dec_o.kind = K_GET; dec_o.wid = W16; dec_o.hi = 1'b1; end
            F_GETH_L: begin dec_o.kind = K_GET; dec_o.wid = W32; dec_o.hi = 1'b1; end
            F_GETH_Q: begin dec_o.kind = K_GET; dec_o.wid = W64; dec_o.hi = 1'b1; end
            F_PUTL_B: begin dec_o.kind = K_PUT; dec_o.wid = W8;  end
            F_PUTL_W: begin dec_o.kind = K_PUT; dec_o.wid = W16; end
            F_PUTL_L: begin dec_o.kind = K_PUT; dec_o.wid = W32; end
            F_PUTL_Q: begin dec_o.kind = K_PUT; dec_o.wid = W64; end
            F_PUTH_W: begin dec_o.kind = K_PUT; dec_o.wid = W16; dec_o.hi = 1'b1; end
            F_PUTH_L: begin dec_o.kind = K_PUT; dec_o.wid = W32; dec_o.hi = 1'b1; end
            F_PUTH_Q: begin dec_o.kind = K_PUT; dec_o.wid = W64; dec_o.hi = 1'b1; end
            F_ZAP:    begin dec_o.kind = K_ZAP; dec_o.inv = 1'b0; end
            F_KEEP:   begin dec_o.kind = K_ZAP; dec_o.inv = 1'b1; end
            default:  dec_o.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/bmx_shift.sv
module bmx_shift
    import bmx_pkg::*;
(
    input  logic [WORD_W-1:0]  a_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  shdir_e             dir_i,
    output logic [WORD_W-1:0]  res_o
);
    always_comb begin
        case (dir_i)
            SH_RL:   res_o = a_i >> amt_i;
            SH_RA:   res_o = WORD_W'($signed(a_i) >>> amt_i);
            default: res_o = a_i << amt_i;
        endcase
    end
endmodule

// File: rtl/bmx_field.sv
module bmx_field
    import bmx_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  kind_e             kind_i,
    input  logic              hi_i,
    input  fwid_e             wid_i,
    output logic [WORD_W-1:0] res_o
);
    localparam int LANE_LG = $clog2(LANE_W);

    logic [SHAMT_W-1:0] sh;     // 8*offset
    logic [SHAMT_W-1:0] neg_sh; // (64 - 8*offset) mod 64
    logic [SHAMT_W:0]   rsh;    // 64 - 8*offset, full range
    logic [WORD_W-1:0]  fm;
    logic [WORD_W-1:0]  a_fld;
    logic               zero_ofs;

    assign sh       = SHAMT_W'(ofs_i) << LANE_LG;
    assign neg_sh   = SHAMT_W'(WORD_W - int'(sh));
    assign rsh      = (SHAMT_W+1)'(WORD_W - int'(sh));
    assign fm       = field_ones(wid_i);
    assign a_fld    = a_i & fm;
    assign zero_ofs = (ofs_i == '0);

    always_comb begin
        res_o = '0;
        case (kind_i)
            K_CLR: begin
                if (!hi_i)         res_o = a_i & ~(fm << sh);
                else if (zero_ofs) res_o = a_i;
                else               res_o = a_i & ~(fm >> rsh);
            end
            K_GET: begin
                if (!hi_i) res_o = (a_i >> sh) & fm;
                else       res_o = (a_i << neg_sh) & fm;
            end
            K_PUT: begin
                if (!hi_i)         res_o = a_fld << sh;
                else if (zero_ofs) res_o = '0;
                else               res_o = a_fld >> rsh;
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/bmx_zap.sv
module bmx_zap
    import bmx_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [LANES-1:0]  lane_i,
    input  logic              inv_i,
    output logic [WORD_W-1:0] res_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic keep;
        assign keep = inv_i ? lane_i[i] : ~lane_i[i];
        assign res_o[i*LANE_W +: LANE_W] = keep ? a_i[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/byte_manip_unit.sv
module byte_manip_unit
    import bmx_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [FUNC_W-1:0] fn_i,
    output logic [WORD_W-1:0] res_o,
    output logic              bad_fn_o
);
    dec_t              dec;
    logic [WORD_W-1:0] sh_res, fld_res, zap_res;
    logic              unused_b_hi;

    assign unused_b_hi = ^b_i[WORD_W-1:LANES];

    bmx_decode u_dec (.fn_i(fn_i), .dec_o(dec));

    bmx_shift u_shift (
        .a_i(a_i), .amt_i(b_i[SHAMT_W-1:0]), .dir_i(dec.dir), .res_o(sh_res)
    );

    bmx_field u_field (
        .a_i(a_i), .ofs_i(b_i[OFS_W-1:0]), .kind_i(dec.kind),
        .hi_i(dec.hi), .wid_i(dec.wid), .res_o(fld_res)
    );

    bmx_zap u_zap (
        .a_i(a_i), .lane_i(b_i[LANES-1:0]), .inv_i(dec.inv), .res_o(zap_res)
    );

    always_comb begin
        case (dec.kind)
            K_SHIFT:             res_o = sh_res;
            K_CLR, K_GET, K_PUT: res_o = fld_res;
            K_ZAP:               res_o = zap_res;
            default:             res_o = '0;
        endcase
    end

    assign bad_fn_o = dec.bad;
endmodule

// File: rtl/bmx_chk.sv
module bmx_chk
    import bmx_pkg::*;
(
    input logic [WORD_W-1:0] a_i,
    input logic [LANES-1:0]  b_lo,
    input logic [FUNC_W-1:0] fn_i,
    input logic [WORD_W-1:0] res_o,
    input logic              bad_fn_o
);
    logic [WORD_W-1:0] lane_bits;
    for (genvar i = 0; i < LANES; i++) begin : g_ln
        assign lane_bits[i*LANE_W +: LANE_W] = {LANE_W{b_lo[i]}};
    end

    always_comb begin
        // R10: an illegal code never leaks data
        a_r10_illegal_zero: assert (!bad_fn_o || res_o == '0)
            else $error("illegal code produced nonzero result");
        // R3: clear-low only removes bits of A
        if (fn_i == F_CLRL_B || fn_i == F_CLRL_W || fn_i == F_CLRL_L || fn_i == F_CLRL_Q)
            a_r3_clear_subset: assert ((res_o & ~a_i) == '0)
                else $error("clear-low set bits absent from A");
        // R4: clear-high at offset zero passes A through
        if ((fn_i == F_CLRH_W || fn_i == F_CLRH_L || fn_i == F_CLRH_Q) && b_lo[2:0] == 3'd0)
            a_r4_clear_high_ofs0: assert (res_o == a_i)
                else $error("clear-high at offset 0 altered A");
        // R5: byte extract yields at most one byte
        if (fn_i == F_GETL_B)
            a_r5_get_byte_width: assert (res_o[WORD_W-1:LANE_W] == '0)
                else $error("byte extract exceeded field width");
        // R6: word extract-high fits in 16 bits
        if (fn_i == F_GETH_W)
            a_r6_get_high_width: assert (res_o[WORD_W-1:2*LANE_W] == '0)
                else $error("word extract-high exceeded field width");
        // R8: insert-high at offset zero is empty
        if ((fn_i == F_PUTH_W || fn_i == F_PUTH_L || fn_i == F_PUTH_Q) && b_lo[2:0] == 3'd0)
            a_r8_put_high_ofs0: assert (res_o == '0)
                else $error("insert-high at offset 0 nonzero");
        // R9: zap clears every selected lane and adds no bits
        if (fn_i == F_ZAP)
            a_r9_zap_lanes: assert ((res_o & lane_bits) == '0 && (res_o & ~a_i) == '0)
                else $error("zap left a selected lane or added bits");
    end
endmodule

bind byte_manip_unit bmx_chk u_chk (
    .a_i(a_i), .b_lo(b_i[7:0]), .fn_i(fn_i), .res_o(res_o), .bad_fn_o(bad_fn_o)
);

// File: tb/byte_manip_unit_test.sv
`timescale 1ns/1ps
module byte_manip_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a, b;
    logic [6:0]  fn;
    logic [63:0] res;
    logic        bad;
    int          n_run = 0;
    int          n_fail = 0;
    logic [63:0] seed = 64'h9e3779b97f4a7c15;

    always #2.5 clk = ~clk;

    byte_manip_unit uut (.a_i(a), .b_i(b), .fn_i(fn), .res_o(res), .bad_fn_o(bad));

    localparam logic [6:0] FIELD_FN [22] = '{
        7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
        7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
        7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77, 7'h31
    };

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic int nbytes(input logic [6:0] f);
        case (f[6:4])
            3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd3: return 8;
            3'd5: return 2; 3'd6: return 4; default: return 8;
        endcase
    endfunction

    function automatic bit legal(input logic [6:0] f);
        case (f)
            7'h39, 7'h34, 7'h3c, 7'h30, 7'h31,
            7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
            7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
            7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag(input logic [6:0] f);
        case (f)
            7'h39, 7'h34, 7'h3c:               return "R1";
            7'h02, 7'h12, 7'h22, 7'h32:        return "R3";
            7'h52, 7'h62, 7'h72:               return "R4";
            7'h06, 7'h16, 7'h26, 7'h36:        return "R5";
            7'h5a, 7'h6a, 7'h7a:               return "R6";
            7'h0b, 7'h1b, 7'h2b, 7'h3b:        return "R7";
            7'h57, 7'h67, 7'h77:               return "R8";
            7'h30, 7'h31:                      return "R9";
            default:                           return "R10";
        endcase
    endfunction

    // Byte-lane reference model written from the requirements
    function automatic logic [63:0] model(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y);
        logic [63:0] r;
        int o, nb, s;
        o  = int'(y[2:0]);
        nb = nbytes(f);
        r  = '0;
        case (f)
            7'h39: r = x << y[5:0];
            7'h34: r = x >> y[5:0];
            7'h3c: r = 64'($signed(x) >>> y[5:0]);
            7'h02, 7'h12, 7'h22, 7'h32: begin
                r = x;
                for (int j = 0; j < 8; j++) if (j >= o && j < o + nb) r[8*j +: 8] = 8'h00;
            end
            7'h52, 7'h62, 7'h72: begin
                r = x;
                if (o != 0) for (int j = 0; j < 8; j++) if (j < o + nb - 8) r[8*j +: 8] = 8'h00;
            end
            7'h06, 7'h16, 7'h26, 7'h36:
                for (int j = 0; j < 8; j++) if (j < nb && j + o < 8) r[8*j +: 8] = x[8*(j+o) +: 8];
            7'h5a, 7'h6a, 7'h7a: begin
                s = (8 - o) % 8;
                for (int j = 0; j < 8; j++) if (j >= s && j < nb) r[8*j +: 8] = x[8*(j-s) +: 8];
            end
            7'h0b, 7'h1b, 7'h2b, 7'h3b:
                for (int j = 0; j < 8; j++) if (j < nb && j + o < 8) r[8*(j+o) +: 8] = x[8*j +: 8];
            7'h57, 7'h67, 7'h77:
                if (o != 0) for (int j = 0; j < 8; j++) if (j + 8 - o < nb) r[8*j +: 8] = x[8*(j+8-o) +: 8];
            7'h30: for (int j = 0; j < 8; j++) if (!y[j]) r[8*j +: 8] = x[8*j +: 8];
            7'h31: for (int j = 0; j < 8; j++) if (y[j])  r[8*j +: 8] = x[8*j +: 8];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic apply_check(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y, input string why);
        logic [63:0] exp_r;
        bit          exp_b;
        @(negedge clk);
        fn = f; a = x; b = y;
        #1;
        exp_r = model(f, x, y);
        exp_b = !legal(f);
        n_run++;
        if (res !== exp_r || bad !== exp_b) begin
            n_fail++;
            $display("FAIL %s %s fn=%h a=%h b=%h actual res=%h bad=%b expected res=%h bad=%b",
                     tag(f), why, f, x, y, res, bad, exp_r, exp_b);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] pats [6];
        fn = 7'h00; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-state check: idle inputs are an illegal code (R10)
        apply_check(7'h00, 64'h0, 64'h0, "idle-state");

        pats[0] = 64'h0123456789abcdef;
        pats[1] = 64'hffffffffffffffff;
        pats[2] = 64'h8000000000000001;
        pats[3] = 64'hfedcba9876543210;
        pats[4] = rnd();
        pats[5] = rnd();

        // R2..R8: every field code at every offset, garbage in B[63:3]
        foreach (FIELD_FN[k])
            for (int o = 0; o < 8; o++)
                for (int p = 0; p < 6; p++)
                    apply_check(FIELD_FN[k], pats[p], (rnd() & ~64'h7) | 64'(o), "R2 offset sweep");

        // R1: all shift amounts, garbage in B[63:6]
        for (int s = 0; s < 64; s++)
            for (int p = 0; p < 4; p++) begin
                apply_check(7'h39, pats[p], (rnd() & ~64'h3f) | 64'(s), "R1 shl");
                apply_check(7'h34, pats[p], (rnd() & ~64'h3f) | 64'(s), "R1 shr");
                apply_check(7'h3c, pats[p], (rnd() & ~64'h3f) | 64'(s), "R1 sar");
            end

        // R9: every lane mask for both polarities
        for (int m = 0; m < 256; m++) begin
            apply_check(7'h30, pats[m % 6], (rnd() & ~64'hff) | 64'(m), "R9 zap");
            apply_check(7'h31, pats[m % 6], (rnd() & ~64'hff) | 64'(m), "R9 keep");
        end

        // R10: full function-code space
        for (int f = 0; f < 128; f++)
            apply_check(7'(f), rnd(), rnd(), "R10 code sweep");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule